// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a serial digital audio stream made of a bit clock, a channel clock and up to three data lines, and turns it into parallel stereo samples. Each data line carries one left/right pair, so three lines give six channels. All lines share the bit clock and the channel clock. The serial inputs are treated as asynchronous to the system clock. They pass through two-stage synchronizers, and all decoding happens in the system clock domain. The system clock must run at least four times faster than the bit clock.

Two configuration inputs choose the framing convention and the word length. Four conventions are supported: MSB-aligned to the channel edge, MSB delayed by one bit, LSB-aligned to the end of the half-frame, and a short frame-sync pulse. Three word lengths are supported: 16, 20 and 24 bits. Configuration is meant to change only while the block is held in reset. Samples arrive MSB first in two's complement. Each lane publishes a 24-bit left sample and a 24-bit right sample. A single strobe shared by all lanes marks each completed stereo pair.

Top module: `aud_rx_top`

## Requirements
- R1: While reset is high and on the cycle after it, every sample output is zero and the valid strobe is low.
- R2: Format code 0 (MSB-first, edge aligned): the bit sampled on the first bit-clock rise after a channel-clock change is the MSB. The word sampled while the channel clock is high is the left sample.
- R3: Format code 1 (one-bit delay): the bit sampled on the rise where the channel-clock change is seen is ignored, and the MSB follows on the next rise. The word sampled while the channel clock is low is the left sample.
- R4: Format code 2 (end aligned): the LSB is the last bit sampled before the next channel-clock change, and all bits before the last word-length bits of a half-frame are discarded. The half with the channel clock high is the left sample.
- R5: Format code 3 (frame sync): a channel-clock pulse that is high for one bit starts a frame. The left word's MSB is sampled on the rise after the pulse, and the right word follows directly after the left word's LSB.
- R6: Word-length code 0 selects 16 bits, code 1 selects 20 bits, and codes 2 and 3 select 24 bits. A shorter word sits in the top bits of the 24-bit output with the unused low bits zero.
- R7: Each of the three data lines is decoded independently into its own left/right pair. Lane k uses output bits [24k+23:24k].
- R8: The valid strobe is high for exactly one system cycle per completed left-then-right pair. Between strobes the sample outputs hold their values.
- R9: Data and channel clock are taken only at bit-clock rising edges. A data change while the bit clock is high has no effect.
- R10: After reset the channel clock level seen at the first bit-clock rise is not treated as an edge. A pair is published only when a complete left word is followed by a complete right word, so a stream that starts mid-frame yields no sample from its partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing format code (0..3) |
| cfg_wlen | input | 2 | Word-length code (0..3) |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrclk_i | input | 1 | Channel clock or frame sync, asynchronous |
| sdata_i | input | NUM_LANES | Serial data, one line per lane |
| smp_left_o | output | 24*NUM_LANES | Left samples, lane k in bits [24k+23:24k] |
| smp_right_o | output | 24*NUM_LANES | Right samples, lane k in bits [24k+23:24k] |
| smp_valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench drives every framing convention with distinct words on each lane. In the end-aligned format it puts ones in the discarded bits, and in the one-bit-delay format it puts ones in the ignored edge bit. A design that counted bit offsets wrongly or swapped left and right would then publish visibly wrong words. The short word lengths use source words with nonzero low bits, so a design that failed to zero-fill would leak them. A glitch run flips the data lines while the bit clock is high, which would corrupt a design that sampled on the wrong edge. A mid-frame start checks that a lone right word or a partial half never raises the strobe.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SMP_W = 24;
    localparam int CNT_W = 6;

    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        FMT_MSB_EDGE  = 2'd0,
        FMT_MSB_DELAY = 2'd1,
        FMT_LSB_END   = 2'd2,
        FMT_SYNC      = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_20  = 2'd1,
        WL_24  = 2'd2,
        WL_24X = 2'd3
    } wlen_e;

    // per-bit control shared by all lanes
    typedef struct packed {
        logic shift;      // bit enters the shift register
        logic commit;     // a word is complete
        logic side_r;     // completed word is the right channel
        logic from_prev;  // word is in the register before this bit
        logic pair_end;   // right word completes a left/right pair
    } lane_ctl_t;

    function automatic logic [CNT_W-1:0] wlen_bits(wlen_e w);
        case (w)
            WL_16:   return CNT_W'(16);
            WL_20:   return CNT_W'(20);
            default: return CNT_W'(24);
        endcase
    endfunction

    function automatic smp_t align_word(smp_t raw, wlen_e w);
        case (w)
            WL_16:   return {raw[15:0], 8'h00};
            WL_20:   return {raw[19:0], 4'h0};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int NUM_LANES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_i,
    input  logic                 lrclk_i,
    input  logic [NUM_LANES-1:0] sdata_i,
    output logic                 bit_stb,
    output logic                 lr_bit,
    output logic [NUM_LANES-1:0] data_bits
);
    localparam int SW = NUM_LANES + 2;

    logic [SW-1:0] stage1;
    logic [SW-1:0] stage2;
    logic          bclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1    <= '0;
            stage2    <= '0;
            bclk_prev <= 1'b0;
        end else begin
            stage1    <= {sdata_i, lrclk_i, bclk_i};
            stage2    <= stage1;
            bclk_prev <= stage2[0];
        end
    end

    assign bit_stb   = stage2[0] & ~bclk_prev;
    assign lr_bit    = stage2[1];
    assign data_bits = stage2[SW-1:2];

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fmt_e      fmt,
    input  wlen_e     wlen,
    input  logic      bit_stb,
    input  logic      lr_bit,
    output lane_ctl_t ctl
);
    logic             seen_q, prev_lr_q, armed_q, side_q, have_left_q;
    logic             armed_n, side_n, have_left_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] wl, wl2;
    logic             lr_edge;

    assign wl      = wlen_bits(wlen);
    assign wl2     = {wl[CNT_W-2:0], 1'b0};
    assign lr_edge = seen_q && (lr_bit != prev_lr_q);

    always_comb begin
        ctl         = '0;
        cnt_n       = cnt_q;
        armed_n     = armed_q;
        side_n      = side_q;
        have_left_n = have_left_q;
        if (bit_stb && seen_q) begin
            case (fmt)
                FMT_MSB_EDGE, FMT_MSB_DELAY: begin
                    if (lr_edge) begin
                        ctl.shift = (fmt == FMT_MSB_EDGE);
                        cnt_n     = (fmt == FMT_MSB_EDGE) ? CNT_W'(1) : '0;
                        side_n    = (fmt == FMT_MSB_EDGE) ? ~lr_bit : lr_bit;
                    end else if (cnt_q < wl) begin
                        ctl.shift = 1'b1;
                        cnt_n     = cnt_q + CNT_W'(1);
                        if (cnt_q == wl - CNT_W'(1)) begin
                            ctl.commit = 1'b1;
                            ctl.side_r = side_q;
                        end
                    end
                end
                FMT_LSB_END: begin
                    ctl.shift = 1'b1;
                    if (lr_edge) begin
                        armed_n = 1'b1;
                        if (armed_q) begin
                            ctl.commit    = 1'b1;
                            ctl.from_prev = 1'b1;
                            ctl.side_r    = ~prev_lr_q;
                        end
                    end
                end
                default: begin
                    if (lr_bit && !prev_lr_q) begin
                        cnt_n = '0;
                    end else if (cnt_q < wl2) begin
                        ctl.shift = 1'b1;
                        cnt_n     = cnt_q + CNT_W'(1);
                        if (cnt_q == wl - CNT_W'(1)) begin
                            ctl.commit = 1'b1;
                        end else if (cnt_q == wl2 - CNT_W'(1)) begin
                            ctl.commit = 1'b1;
                            ctl.side_r = 1'b1;
                        end
                    end
                end
            endcase
        end
        ctl.pair_end = ctl.commit && ctl.side_r && have_left_q;
        if (ctl.commit) begin
            have_left_n = ~ctl.side_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q      <= 1'b0;
            prev_lr_q   <= 1'b0;
            armed_q     <= 1'b0;
            side_q      <= 1'b0;
            have_left_q <= 1'b0;
            cnt_q       <= '1;
        end else begin
            cnt_q       <= cnt_n;
            armed_q     <= armed_n;
            side_q      <= side_n;
            have_left_q <= have_left_n;
            if (bit_stb) begin
                seen_q    <= 1'b1;
                prev_lr_q <= lr_bit;
            end
        end
    end

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane
    import aud_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wlen_e     wlen,
    input  logic      bit_stb,
    input  lane_ctl_t ctl,
    input  logic      data_bit,
    output smp_t      left_o,
    output smp_t      right_o
);
    smp_t sr_q, sr_next, left_hold_q, word;

    assign sr_next = {sr_q[SMP_W-2:0], data_bit};
    assign word    = align_word(ctl.from_prev ? sr_q : sr_next, wlen);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q        <= '0;
            left_hold_q <= '0;
            left_o      <= '0;
            right_o     <= '0;
        end else if (bit_stb) begin
            if (ctl.shift) begin
                sr_q <= sr_next;
            end
            if (ctl.commit && !ctl.side_r) begin
                left_hold_q <= word;
            end
            if (ctl.pair_end) begin
                left_o  <= left_hold_q;
                right_o <= word;
            end
        end
    end

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
    import aud_rx_pkg::*;
#(
    parameter int NUM_LANES = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 cfg_fmt,
    input  logic [1:0]                 cfg_wlen,
    input  logic                       bclk_i,
    input  logic                       lrclk_i,
    input  logic [NUM_LANES-1:0]       sdata_i,
    output logic [NUM_LANES*SMP_W-1:0] smp_left_o,
    output logic [NUM_LANES*SMP_W-1:0] smp_right_o,
    output logic                       smp_valid_o
);
    logic                 bit_stb, lr_bit;
    logic [NUM_LANES-1:0] data_bits;
    lane_ctl_t            ctl;

    aud_rx_sync #(.NUM_LANES(NUM_LANES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .bclk_i    (bclk_i),
        .lrclk_i   (lrclk_i),
        .sdata_i   (sdata_i),
        .bit_stb   (bit_stb),
        .lr_bit    (lr_bit),
        .data_bits (data_bits)
    );

    aud_rx_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt_e'(cfg_fmt)),
        .wlen    (wlen_e'(cfg_wlen)),
        .bit_stb (bit_stb),
        .lr_bit  (lr_bit),
        .ctl     (ctl)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        aud_rx_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .wlen     (wlen_e'(cfg_wlen)),
            .bit_stb  (bit_stb),
            .ctl      (ctl),
            .data_bit (data_bits[k]),
            .left_o   (smp_left_o[k*SMP_W +: SMP_W]),
            .right_o  (smp_right_o[k*SMP_W +: SMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid_o <= 1'b0;
        end else begin
            smp_valid_o <= bit_stb && ctl.pair_end;
        end
    end

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
    parameter int NUM_LANES = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              cfg_wlen,
    input logic [NUM_LANES*24-1:0] smp_left_o,
    input logic [NUM_LANES*24-1:0] smp_right_o,
    input logic                    smp_valid_o
);
    localparam int SW = 24;

    // R1: outputs cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!smp_valid_o && smp_left_o == '0 && smp_right_o == '0));

    // R8: strobe lasts one cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        smp_valid_o |=> !smp_valid_o);

    // R8: left samples hold between strobes
    p_hold_left_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid_o |-> $stable(smp_left_o));

    // R8: right samples hold between strobes
    p_hold_right_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid_o |-> $stable(smp_right_o));

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_fill
        // R6: 16-bit words leave eight zero LSBs
        p_zero_fill16_r6: assert property (@(posedge clk) disable iff (rst)
            (smp_valid_o && cfg_wlen == 2'd0) |->
            (smp_left_o[k*SW +: 8] == 8'h0 && smp_right_o[k*SW +: 8] == 8'h0));
        // R6: 20-bit words leave four zero LSBs
        p_zero_fill20_r6: assert property (@(posedge clk) disable iff (rst)
            (smp_valid_o && cfg_wlen == 2'd1) |->
            (smp_left_o[k*SW +: 4] == 4'h0 && smp_right_o[k*SW +: 4] == 4'h0));
    end

endmodule

bind aud_rx_top aud_rx_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wlen    (cfg_wlen),
    .smp_left_o  (smp_left_o),
    .smp_right_o (smp_right_o),
    .smp_valid_o (smp_valid_o)
);

// File: tb/tb_aud_rx_top.sv
`timescale 1ns/1ps
module tb_aud_rx_top;
    localparam int NL = 3;
    localparam int BH = 80;   // half bit-clock period in ns
    localparam int HB = 32;   // bits per half-frame

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_fmt = 2'd0;
    logic [1:0]    cfg_wlen = 2'd2;
    logic          bclk = 1'b0;
    logic          lrclk = 1'b0;
    logic [NL-1:0] sdata = '0;
    logic [NL*24-1:0] smp_left_o, smp_right_o;
    logic          smp_valid_o;

    always #10 clk = ~clk;

    aud_rx_top #(.NUM_LANES(NL)) dut (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
        .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
        .smp_left_o(smp_left_o), .smp_right_o(smp_right_o),
        .smp_valid_o(smp_valid_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int vcnt  = 0;
    int dbl   = 0;
    bit vprev = 1'b0;
    logic [NL*24-1:0] hist_l [8];
    logic [NL*24-1:0] hist_r [8];

    always @(negedge clk) begin
        if (smp_valid_o) begin
            hist_l[vcnt % 8] = smp_left_o;
            hist_r[vcnt % 8] = smp_right_o;
            vcnt++;
            if (vprev) dbl++;
        end
        vprev = smp_valid_o;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] trim(logic [23:0] w, int wl);
        return w & ~((24'h1 << (24 - wl)) - 24'h1);
    endfunction

    task automatic put_bit(logic lr, logic [NL-1:0] d, bit glitch);
        bclk = 1'b0; lrclk = lr; sdata = d;
        #BH;
        bclk = 1'b1;
        if (glitch) begin
            #50; sdata = ~d; #(BH - 50);
        end else begin
            #BH;
        end
    endtask

    task automatic do_reset(logic [1:0] fmt, logic [1:0] wcode);
        rst = 1'b1; bclk = 1'b0; lrclk = 1'b0; sdata = '0;
        cfg_fmt = fmt; cfg_wlen = wcode;
        repeat (4) @(posedge clk);
        #3 rst = 1'b0;
        @(posedge clk); #3;
    endtask

    task automatic send_frame(logic [1:0] fmt, int wl, logic [NL-1:0][23:0] lw,
                              logic [NL-1:0][23:0] rw, bit glitch);
        if (fmt == 2'd3) begin
            for (int i = 0; i < 2*HB; i++) begin
                logic [NL-1:0] d;
                for (int k = 0; k < NL; k++) begin
                    if (i >= 1 && i <= wl) d[k] = lw[k][24 - i];
                    else if (i > wl && i <= 2*wl) d[k] = rw[k][24 - (i - wl)];
                    else d[k] = 1'b0;
                end
                put_bit(i == 0, d, glitch);
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                for (int i = 0; i < HB; i++) begin
                    logic [NL-1:0] d;
                    logic lvl;
                    lvl = (fmt == 2'd1) ? (h == 1) : (h == 0);
                    for (int k = 0; k < NL; k++) begin
                        logic [23:0] w;
                        w = (h == 0) ? lw[k] : rw[k];
                        if (fmt == 2'd0)
                            d[k] = (i < wl) ? w[23 - i] : 1'b0;
                        else if (fmt == 2'd1)
                            d[k] = (i == 0) ? 1'b1 : (i <= wl) ? w[24 - i] : 1'b0;
                        else
                            d[k] = (i >= HB - wl) ? w[23 - (i - (HB - wl))] : 1'b1;
                    end
                    put_bit(lvl, d, glitch);
                end
            end
        end
    endtask

    task automatic check_pair(string tag, int slot, int wl,
                              logic [NL-1:0][23:0] lw, logic [NL-1:0][23:0] rw);
        for (int k = 0; k < NL; k++) begin
            chk($sformatf("%s R7 lane%0d left", tag, k),
                {8'h0, hist_l[slot % 8][k*24 +: 24]}, {8'h0, trim(lw[k], wl)});
            chk($sformatf("%s R7 lane%0d right", tag, k),
                {8'h0, hist_r[slot % 8][k*24 +: 24]}, {8'h0, trim(rw[k], wl)});
        end
    endtask

    // one scenario: two frames in the given format, both pairs checked
    task automatic run_fmt(string tag, logic [1:0] fmt, logic [1:0] wcode, int wl, bit glitch);
        logic [NL-1:0][23:0] al, ar, bl, br;
        logic pad_lvl, end_lvl;
        int v0;
        al = {24'h812345, 24'h7FEDCB, 24'hA5C3E1};
        ar = {24'h1F2E3D, 24'hC0FFEE, 24'h00000F};
        bl = {24'hFFFFFF, 24'h000001, 24'h5A5A5A};
        br = {24'h800000, 24'h7FFFFF, 24'h3C96E7};
        pad_lvl = (fmt == 2'd1);
        end_lvl = (fmt == 2'd0 || fmt == 2'd2);
        do_reset(fmt, wcode);
        for (int i = 0; i < 3; i++) put_bit(pad_lvl, '0, glitch);
        v0 = vcnt;
        send_frame(fmt, wl, al, ar, glitch);
        send_frame(fmt, wl, bl, br, glitch);
        for (int i = 0; i < 4; i++) put_bit(end_lvl, '0, glitch);
        repeat (10) @(posedge clk);
        #3;
        chk({tag, " R8 pair count"}, vcnt - v0, 2);
        check_pair({tag, " first"}, v0, wl, al, ar);
        check_pair({tag, " second"}, v0 + 1, wl, bl, br);
    endtask

    task automatic test_reset();
        do_reset(2'd0, 2'd2);
        repeat (20) @(posedge clk);
        #3;
        chk("R1 valid after reset", smp_valid_o, 0);
        chk("R1 left after reset", smp_left_o[31:0], 0);
        chk("R1 right after reset", smp_right_o[31:0], 0);
        chk("R1 no strobe while idle", vcnt, 0);
    endtask

    // R10: stream starts mid-left, then a lone right half, then a full frame
    task automatic test_partial_start();
        logic [NL-1:0][23:0] jl, al, ar;
        int v0;
        jl = {24'h111111, 24'h222222, 24'h333333};
        al = {24'h9ABCDE, 24'h13579B, 24'hF0F0F0};
        ar = {24'h2468AC, 24'hEDCBA9, 24'h0F0F0F};
        do_reset(2'd0, 2'd2);
        v0 = vcnt;
        for (int i = 0; i < 10; i++) put_bit(1'b1, '1, 1'b0);
        for (int i = 0; i < HB; i++) begin
            logic [NL-1:0] d;
            for (int k = 0; k < NL; k++) d[k] = (i < 24) ? jl[k][23 - i] : 1'b0;
            put_bit(1'b0, d, 1'b0);
        end
        repeat (10) @(posedge clk);
        #3;
        chk("R10 no pair from partial frame", vcnt - v0, 0);
        send_frame(2'd0, 24, al, ar, 1'b0);
        for (int i = 0; i < 4; i++) put_bit(1'b1, '0, 1'b0);
        repeat (10) @(posedge clk);
        #3;
        chk("R10 one pair after full frame", vcnt - v0, 1);
        check_pair("R10 R2", v0, 24, al, ar);
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        test_reset();
        run_fmt("R2 edge-aligned 24b", 2'd0, 2'd2, 24, 1'b0);
        run_fmt("R3 delayed 24b", 2'd1, 2'd2, 24, 1'b0);
        run_fmt("R4 R6 end-aligned 16b", 2'd2, 2'd0, 16, 1'b0);
        run_fmt("R5 R6 sync 20b", 2'd3, 2'd1, 20, 1'b0);
        run_fmt("R3 R6 delayed 16b", 2'd1, 2'd0, 16, 1'b0);
        run_fmt("R4 R6 end-aligned code3", 2'd2, 2'd3, 24, 1'b0);
        run_fmt("R9 R2 glitch 20b", 2'd0, 2'd1, 20, 1'b1);
        run_fmt("R9 R5 glitch 24b", 2'd3, 2'd2, 24, 1'b1);
        test_partial_start();
        chk("R8 strobe never two cycles", dbl, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule